// File: doc/BRIEF.md
# Command Slot Issue Tracker

This block keeps the per-port slot bookkeeping of a SATA host port that runs native command queuing. It holds two 32-bit masks, one bit per command slot. The issue mask marks slots whose command has been handed to the port. The active mask marks queued slots that the device still owes a completion for. Software only ever sets bits, through a small write port. Hardware events from the transport side only ever clear them: a received FIS that drops BSY and DRQ for one slot, a Set Device Bits FIS carrying a mask of finished slots, the port start bit going low, a COMRESET, or a software reset.

For queued work, software first marks the slot active and then marks it issued. Issue writes count only while the port start bit is high. The block also names the lowest issued slot, so that downstream command-fetch logic can take slots in ascending order.

Top module: `slot_issue_tracker`

## Requirements
- R1: After reset both masks are 00000000h, reads at both offsets return 0, and `fetch_valid` is 0.
- R2: The active mask is written at offset 34h and the issue mask at offset 38h. A 1 in the write data sets that bit, a 0 leaves it unchanged, and the new value is visible on the mask outputs and on a read of the same offset one cycle after the write.
- R3: A write to the issue offset while `port_start` is 0 has no effect on the issue mask.
- R4: A BSY/DRQ-clear event for slot index k clears issue bit k only, one cycle later.
- R5: A Set Device Bits event clears every active bit that is 1 in its completion mask, and leaves all other active bits unchanged.
- R6: A 1-to-0 transition of `port_start` clears both masks. The issue mask stays at 0 while `port_start` is 0.
- R7: `link_comreset` or `sw_srst` clears the active mask one cycle later and leaves the issue mask unchanged.
- R8: When a hardware clear and a software set target the same bit in the same cycle, the bit ends up 0.
- R9: `fetch_valid` is 1 exactly when some issue bit is set, and `fetch_slot` is then the index of the lowest set issue bit.
- R10: Writes to any offset other than 34h and 38h change nothing, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_ofs | input | 7 | Offset of the write within the port window |
| sw_wr_data | input | 32 | Write data, 1 bits set slots |
| sw_rd_ofs | input | 7 | Offset of the read within the port window |
| sw_rd_data | output | 32 | Read data for `sw_rd_ofs` |
| port_start | input | 1 | Port start bit from the command register |
| bsy_drq_clr_valid | input | 1 | A FIS cleared BSY and DRQ for one slot |
| bsy_drq_clr_slot | input | 5 | Slot index of that FIS |
| sdb_valid | input | 1 | A Set Device Bits FIS arrived |
| sdb_done_mask | input | 32 | Completion mask carried by that FIS |
| link_comreset | input | 1 | COMRESET issued on the link |
| sw_srst | input | 1 | Software reset to the device |
| issue_mask | output | 32 | Issued slots |
| active_mask | output | 32 | Queued slots still outstanding at the device |
| fetch_valid | output | 1 | At least one slot is issued |
| fetch_slot | output | 5 | Lowest issued slot index |

## Verification
The hardest case to reach from the ports is a collision: a software set and a hardware clear that land on the same bit in the same cycle, because the two normally come from unrelated agents. The bench drives both in one cycle on purpose, once for each mask (issue write against a BSY/DRQ clear, active write against a completion mask and against COMRESET). It also drops the start bit with slots pending, then attempts issue writes while the port is stopped, to show that the stop clears both masks and that the masks stay cleared.

// File: rtl/slot_trk_pkg.sv
// Package: shared constants of the command slot tracker.
// Assumes one instance per port; offsets are relative to the port window.
package slot_trk_pkg;
    localparam int          SLOT_CNT   = 32;
    localparam int          OFS_W      = 7;
    localparam logic [6:0]  OFS_ACTIVE = 7'h34;
    localparam logic [6:0]  OFS_ISSUE  = 7'h38;
endpackage

// File: rtl/slot_bit_bank.sv
// Module: bank of set/clear flag bits, one per slot.
// Each bit is set by set_mask and cleared by clr_mask; clear has priority.
// Assumes synchronous active-low reset to all zeros.
module slot_bit_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        // Update one flag: reset, then clear, then set.
        always_ff @(posedge clk) begin
            if (!rst_n)           bit_q <= 1'b0;
            else if (clr_mask[i]) bit_q <= 1'b0;
            else if (set_mask[i]) bit_q <= 1'b1;
        end
        assign q[i] = bit_q;
    end
endmodule

// File: rtl/slot_sw_decode.sv
// Module: turns a software write into set masks for the two flag banks.
// Assumes writes to unknown offsets are dropped and issue writes need the
// port to be started.
module slot_sw_decode
    import slot_trk_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [W-1:0]     wr_data,
    input  logic             port_start,
    output logic [W-1:0]     act_set,
    output logic [W-1:0]     iss_set
);
    // Route write data to the selected bank only.
    always_comb begin
        act_set = '0;
        iss_set = '0;
        if (wr_en) begin
            if (wr_ofs == OFS_ACTIVE)               act_set = wr_data;
            if (wr_ofs == OFS_ISSUE && port_start)  iss_set = wr_data;
        end
    end
endmodule

// File: rtl/slot_lowest_pick.sv
// Module: finds the lowest set bit of a mask.
// Assumes a plain combinational scan is short enough for the clock.
module slot_lowest_pick #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     mask,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/slot_issue_tracker.sv
// Module: per-port command slot tracker (issue and active masks).
// Software sets bits; link/transport events clear them. Assumes event
// inputs are single-cycle pulses synchronous to clk.
module slot_issue_tracker
    import slot_trk_pkg::*;
#(
    parameter int SLOTS = SLOT_CNT,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr_en,
    input  logic [OFS_W-1:0] sw_wr_ofs,
    input  logic [SLOTS-1:0] sw_wr_data,
    input  logic [OFS_W-1:0] sw_rd_ofs,
    output logic [SLOTS-1:0] sw_rd_data,
    input  logic             port_start,
    input  logic             bsy_drq_clr_valid,
    input  logic [IDX_W-1:0] bsy_drq_clr_slot,
    input  logic             sdb_valid,
    input  logic [SLOTS-1:0] sdb_done_mask,
    input  logic             link_comreset,
    input  logic             sw_srst,
    output logic [SLOTS-1:0] issue_mask,
    output logic [SLOTS-1:0] active_mask,
    output logic             fetch_valid,
    output logic [IDX_W-1:0] fetch_slot
);
    logic             start_q;
    logic             stop_evt;
    logic [SLOTS-1:0] act_set, iss_set;
    logic [SLOTS-1:0] act_clr, iss_clr;

    // Remember the start bit to see its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= port_start;
    end

    assign stop_evt = start_q & ~port_start;

    // Build the hardware clear masks for both banks.
    always_comb begin
        iss_clr = {SLOTS{~port_start}};
        if (bsy_drq_clr_valid) iss_clr[bsy_drq_clr_slot] = 1'b1;
        act_clr = {SLOTS{stop_evt | link_comreset | sw_srst}};
        if (sdb_valid) act_clr = act_clr | sdb_done_mask;
    end

    slot_sw_decode #(.W(SLOTS)) u_dec (
        .wr_en      (sw_wr_en),
        .wr_ofs     (sw_wr_ofs),
        .wr_data    (sw_wr_data),
        .port_start (port_start),
        .act_set    (act_set),
        .iss_set    (iss_set)
    );

    slot_bit_bank #(.W(SLOTS)) u_active (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (act_set),
        .clr_mask (act_clr),
        .q        (active_mask)
    );

    slot_bit_bank #(.W(SLOTS)) u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (iss_set),
        .clr_mask (iss_clr),
        .q        (issue_mask)
    );

    slot_lowest_pick #(.W(SLOTS), .IDX_W(IDX_W)) u_pick (
        .mask  (issue_mask),
        .found (fetch_valid),
        .idx   (fetch_slot)
    );

    // Read mux: known offsets return their mask, others zero.
    always_comb begin
        case (sw_rd_ofs)
            OFS_ACTIVE: sw_rd_data = active_mask;
            OFS_ISSUE:  sw_rd_data = issue_mask;
            default:    sw_rd_data = '0;
        endcase
    end
endmodule

// File: rtl/slot_issue_tracker_chk.sv
// Module: property checker bound to the slot tracker; observes ports only.
module slot_issue_tracker_chk #(
    parameter int SLOTS = 32,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_wr_en,
    input logic             port_start,
    input logic             bsy_drq_clr_valid,
    input logic [IDX_W-1:0] bsy_drq_clr_slot,
    input logic             sdb_valid,
    input logic [SLOTS-1:0] sdb_done_mask,
    input logic             link_comreset,
    input logic             sw_srst,
    input logic [SLOTS-1:0] issue_mask,
    input logic [SLOTS-1:0] active_mask,
    input logic             fetch_valid,
    input logic [IDX_W-1:0] fetch_slot
);
    AST_ISS_ZERO_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !port_start |=> issue_mask == '0);  // R6
    AST_BSY_CLEARS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        bsy_drq_clr_valid |=> !issue_mask[$past(bsy_drq_clr_slot)]);  // R4
    AST_SDB_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        sdb_valid |=> (active_mask & $past(sdb_done_mask)) == '0);  // R5
    AST_LINK_RST_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (link_comreset || sw_srst) |=> active_mask == '0);  // R7
    AST_ISS_SW_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_en |=> (issue_mask & ~$past(issue_mask)) == '0);  // R3
    AST_ACT_SW_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_en |=> (active_mask & ~$past(active_mask)) == '0);  // R2
    AST_FETCH_POINTS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> issue_mask[fetch_slot]);  // R9
    AST_FETCH_VALID_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid == (issue_mask != '0));  // R9
endmodule

bind slot_issue_tracker slot_issue_tracker_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .sw_wr_en          (sw_wr_en),
    .port_start        (port_start),
    .bsy_drq_clr_valid (bsy_drq_clr_valid),
    .bsy_drq_clr_slot  (bsy_drq_clr_slot),
    .sdb_valid         (sdb_valid),
    .sdb_done_mask     (sdb_done_mask),
    .link_comreset     (link_comreset),
    .sw_srst           (sw_srst),
    .issue_mask        (issue_mask),
    .active_mask       (active_mask),
    .fetch_valid       (fetch_valid),
    .fetch_slot        (fetch_slot)
);

// File: tb/slot_issue_tracker_bench.sv
module slot_issue_tracker_bench;
    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_BSY = 2'd1;
    localparam logic [1:0] OP_SDB = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [6:0]  ofs;
        logic [31:0] dat;
        logic [31:0] e_act;
        logic [31:0] e_iss;
    } vec_t;

    // R2 R4 R5 R10: sequence with port started; expected masks after each step.
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{OP_WR,  7'h34, 32'h0000_00F0, 32'h0000_00F0, 32'h0000_0000},
        '{OP_WR,  7'h38, 32'h0000_0030, 32'h0000_00F0, 32'h0000_0030},
        '{OP_WR,  7'h38, 32'h8000_0000, 32'h0000_00F0, 32'h8000_0030},
        '{OP_WR,  7'h34, 32'h0000_0000, 32'h0000_00F0, 32'h8000_0030},
        '{OP_BSY, 7'h00, 32'd4,         32'h0000_00F0, 32'h8000_0020},
        '{OP_SDB, 7'h00, 32'h0000_0030, 32'h0000_00C0, 32'h8000_0020},
        '{OP_WR,  7'h3C, 32'hFFFF_FFFF, 32'h0000_00C0, 32'h8000_0020},
        '{OP_BSY, 7'h00, 32'd31,        32'h0000_00C0, 32'h0000_0020},
        '{OP_SDB, 7'h00, 32'hFFFF_FF00, 32'h0000_00C0, 32'h0000_0020}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_wr_en;
    logic [6:0]  sw_wr_ofs;
    logic [31:0] sw_wr_data;
    logic [6:0]  sw_rd_ofs;
    logic [31:0] sw_rd_data;
    logic        port_start;
    logic        bsy_drq_clr_valid;
    logic [4:0]  bsy_drq_clr_slot;
    logic        sdb_valid;
    logic [31:0] sdb_done_mask;
    logic        link_comreset;
    logic        sw_srst;
    logic [31:0] issue_mask;
    logic [31:0] active_mask;
    logic        fetch_valid;
    logic [4:0]  fetch_slot;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    slot_issue_tracker u_slot_issue_tracker (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        sw_wr_en = 0; sw_wr_ofs = '0; sw_wr_data = '0;
        bsy_drq_clr_valid = 0; bsy_drq_clr_slot = '0;
        sdb_valid = 0; sdb_done_mask = '0; link_comreset = 0; sw_srst = 0;
    endtask

    // Inputs set at negedge; one posedge applies them; return at next negedge.
    task automatic tick();
        @(posedge clk);
        #1 idle();
        @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] ofs, input logic [31:0] d);
        sw_wr_en = 1; sw_wr_ofs = ofs; sw_wr_data = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        sw_rd_ofs = 7'h34; port_start = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 act", active_mask, 32'h0);
        chk("R1 iss", issue_mask, 32'h0);
        chk("R1 rd", sw_rd_data, 32'h0);
        chk("R1 fetch_valid", {31'b0, fetch_valid}, 32'h0);

        port_start = 1;
        tick();
        for (int v = 0; v < NV; v++) begin
            case (VECS[v].op)
                OP_WR:  wr(VECS[v].ofs, VECS[v].dat);
                OP_BSY: begin bsy_drq_clr_valid = 1; bsy_drq_clr_slot = VECS[v].dat[4:0]; end
                default: begin sdb_valid = 1; sdb_done_mask = VECS[v].dat; end
            endcase
            tick();
            chk("R2/R4/R5/R10 table act", active_mask, VECS[v].e_act);
            chk("R2/R4/R5/R10 table iss", issue_mask, VECS[v].e_iss);
        end
        // R2 readback at both offsets, R10 unknown offset reads zero
        sw_rd_ofs = 7'h34; #1 chk("R2 rd act", sw_rd_data, 32'h0000_00C0);
        sw_rd_ofs = 7'h38; #1 chk("R2 rd iss", sw_rd_data, 32'h0000_0020);
        sw_rd_ofs = 7'h3C; #1 chk("R10 rd unknown", sw_rd_data, 32'h0);
        // R9 lowest slot
        chk("R9 fetch_slot", {27'b0, fetch_slot}, 32'd5);
        chk("R9 fetch_valid", {31'b0, fetch_valid}, 32'd1);
        wr(7'h38, 32'h0000_0408); tick();
        chk("R9 fetch_slot lower", {27'b0, fetch_slot}, 32'd3);

        // R8 collisions
        wr(7'h38, 32'h0000_0080); bsy_drq_clr_valid = 1; bsy_drq_clr_slot = 5'd7; tick();
        chk("R8 iss collision", issue_mask, 32'h0000_0428);
        wr(7'h34, 32'h0000_0002); sdb_valid = 1; sdb_done_mask = 32'h0000_0002; tick();
        chk("R8 act collision sdb", active_mask, 32'h0000_00C0);
        wr(7'h34, 32'h0000_0100); link_comreset = 1; tick();
        chk("R8 act collision comreset", active_mask, 32'h0);

        // R7 link and software resets
        wr(7'h34, 32'h0000_0F00); tick();
        chk("R7 act set", active_mask, 32'h0000_0F00);
        link_comreset = 1; tick();
        chk("R7 comreset act", active_mask, 32'h0);
        chk("R7 comreset iss kept", issue_mask, 32'h0000_0428);
        wr(7'h34, 32'h0000_0003); tick();
        sw_srst = 1; tick();
        chk("R7 srst act", active_mask, 32'h0);
        chk("R7 srst iss kept", issue_mask, 32'h0000_0428);

        // R6 stop clears both; R3 issue write ignored while stopped
        wr(7'h34, 32'h0000_0050); tick();
        port_start = 0; tick();
        chk("R6 stop act", active_mask, 32'h0);
        chk("R6 stop iss", issue_mask, 32'h0);
        wr(7'h38, 32'hFFFF_FFFF); tick();
        chk("R3 iss ignored", issue_mask, 32'h0);
        sw_rd_ofs = 7'h38; #1 chk("R3 rd iss", sw_rd_data, 32'h0);
        chk("R9 none valid", {31'b0, fetch_valid}, 32'h0);
        port_start = 1; tick();
        wr(7'h38, 32'h0000_0001); tick();
        chk("R3 iss after restart", issue_mask, 32'h0000_0001);
        chk("R9 slot0", {27'b0, fetch_slot}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule